// File: doc/BRIEF.md
# Chained Buffer DMA Channel

One DMA channel copies a stream of fixed-length buffers. The buffers come from a circular set of source buffers and go to a circular set of destination buffers. Each set is described in memory by an array of 64-bit descriptors. Bit 63 of a descriptor marks the buffer as full (1) or empty (0). The low address bits of the descriptor give the buffer's physical address. A source buffer is consumed only when it is full, and a destination buffer is filled only when it is empty. After each copy, the channel hands the source buffer back as empty and the destination buffer on as full, so a producer and a consumer can share the rings with the channel.

Software programs the two ring base addresses, the two ring lengths, the buffer length and a period. It then starts the channel through a control register. A nonzero period selects strict in-order operation: the channel polls the expected descriptor with that many idle cycles between attempts. A zero period selects out-of-order operation: the channel moves on to the next descriptor at once, so it takes the first full source and the first empty destination, with the search start rotating past the last buffer used.

Every memory access goes through a single-outstanding request/response master port. An error response stops the channel, records which kind of access failed and raises the interrupt until software writes stop.

Top module: `chain_dma_chan`

## Requirements
- R1: After reset the period register (reg_addr 7) reads 0, the status register (reg_addr 9) reads 0, irq is low and mem_req is low.
- R2: The descriptor of ring index i is accessed as a 64-bit access (mem_wide=1) at base + 8*i. A data word at byte offset k is accessed as a 32-bit access (mem_wide=0, data in bits 31:0) at the buffer address plus k. A request holds its address until it is acknowledged.
- R3: A source buffer is read only after its descriptor shows bit 63 = 1. A destination buffer is written only after its descriptor shows bit 63 = 0.
- R4: A copy of length L bytes (L a nonzero multiple of 4) is L/4 read-then-write pairs at ascending offsets 0, 4, ... Each write carries the word that the preceding read returned.
- R5: After the last data word, the source descriptor is written with bit 63 = 0, bits 62:48 = 0 and its address unchanged. Then the destination descriptor is written with bit 63 = 1, bits 62:48 = 0 and its address unchanged.
- R6: With a nonzero period P, the source and destination indices each advance by one modulo their ring length after every copy. A descriptor in the wrong state is read again at the same index after exactly P cycles without a request.
- R7: With period 0, a descriptor in the wrong state makes the channel read the next index (modulo ring length) in the very next request slot. After a copy, each index points just past the buffer it used.
- R8: An error response stops all further requests, raises irq from the next cycle and records code 1 (source descriptor, read or write), 2 (source data), 3 (destination descriptor, read or write) or 4 (destination data).
- R9: Writing the control register (reg_addr 8) with bit 0 = 0 makes the channel idle from the next cycle: no request, irq low, error code cleared. This holds even in the cycle an error response arrives.
- R10: Writing the control register with bit 0 = 1 while the channel is idle or in error clears both indices and issues a source descriptor read at index 0 next cycle. The same write while the channel is running has no effect.
- R11: The status register holds the phase in bits 1:0 (0 idle, 1 scanning or polling, 2 copying, 3 error), the error code in bits 6:4, the source index in bits 15:8 and the destination index in bits 23:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index: 0/1 source base low/high, 2 source count, 3/4 destination base low/high, 5 destination count, 6 length, 7 period, 8 control, 9 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_wide | output | 1 | 1: 64-bit descriptor access, 0: 32-bit data word |
| mem_addr | output | AW (48) | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Response strobe for the pending request |
| mem_rdata | input | 64 | Read data with the response |
| mem_err | input | 1 | Response carries an error |
| irq | output | 1 | High while the channel is halted on an error |

## Verification
The two functions that can fall in the same cycle are a stop write from software and an error response from memory. Each one, taken alone, sends the channel to a different final state. The bench waits for the cycle in which an error response is presented and drives the stop write into that same clock edge. It then judges from the ports and the status register that the channel ends idle with irq low and no error code. A start write sent while the channel is scanning is a second collision of this kind: the bench judges it by the destination index staying where the last copy left it.

// File: rtl/chain_dma_chan.sv
module chain_dma_chan #(
  parameter int AW    = 48,
  parameter int IDX_W = 8,
  parameter int LEN_W = 16,
  parameter int PER_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_wide,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [63:0]   mem_rdata,
  input  logic          mem_err,
  output logic          irq
);

  typedef enum logic [3:0] {
    S_IDLE, S_SRD, S_SWT, S_DRD, S_DWT, S_RD, S_WR, S_SWB, S_DWB, S_ERR
  } st_t;

  st_t              state;
  logic [AW-1:0]    src_base, dst_base, src_pa, dst_pa;
  logic [IDX_W-1:0] src_cnt, dst_cnt, si, di, si_nx, di_nx;
  logic [LEN_W-1:0] buf_len, off;
  logic [PER_W-1:0] period, wcnt;
  logic [31:0]      dbuf;
  logic [2:0]       err_code;
  logic [1:0]       phase;
  logic             ctrl_wr, start, stop, ok, bad, last, running, in_order;

  assign ctrl_wr  = reg_wr && reg_addr == 4'd8;
  assign running  = state != S_IDLE && state != S_ERR;
  assign start    = ctrl_wr && reg_wdata[0] && !running;
  assign stop     = ctrl_wr && !reg_wdata[0];
  assign ok       = mem_req && mem_ack && !mem_err;
  assign bad      = mem_req && mem_ack && mem_err;
  assign in_order = period != '0;
  assign last     = ({1'b0, off} + (LEN_W+1)'(4)) >= {1'b0, buf_len};
  assign si_nx    = (si == src_cnt - 1'b1) ? '0 : si + 1'b1;
  assign di_nx    = (di == dst_cnt - 1'b1) ? '0 : di + 1'b1;
  assign irq      = state == S_ERR;

  assign mem_req  = state inside {S_SRD, S_DRD, S_RD, S_WR, S_SWB, S_DWB};
  assign mem_we   = state inside {S_WR, S_SWB, S_DWB};
  assign mem_wide = state inside {S_SRD, S_DRD, S_SWB, S_DWB};

  always_comb begin
    case (state)
      S_SRD, S_SWB: mem_addr = src_base + (AW'(si) << 3);
      S_DRD, S_DWB: mem_addr = dst_base + (AW'(di) << 3);
      S_RD:         mem_addr = src_pa + AW'(off);
      S_WR:         mem_addr = dst_pa + AW'(off);
      default:      mem_addr = '0;
    endcase
    case (state)
      S_WR:    mem_wdata = {32'h0, dbuf};
      S_SWB:   mem_wdata = {1'b0, {(63-AW){1'b0}}, src_pa};
      S_DWB:   mem_wdata = {1'b1, {(63-AW){1'b0}}, dst_pa};
      default: mem_wdata = '0;
    endcase
    case (state)
      S_IDLE:                    phase = 2'd0;
      S_SRD, S_SWT, S_DRD, S_DWT: phase = 2'd1;
      S_ERR:                     phase = 2'd3;
      default:                   phase = 2'd2;
    endcase
    case (reg_addr)
      4'd0:    reg_rdata = src_base[31:0];
      4'd1:    reg_rdata = 32'(src_base[AW-1:32]);
      4'd2:    reg_rdata = 32'(src_cnt);
      4'd3:    reg_rdata = dst_base[31:0];
      4'd4:    reg_rdata = 32'(dst_base[AW-1:32]);
      4'd5:    reg_rdata = 32'(dst_cnt);
      4'd6:    reg_rdata = 32'(buf_len);
      4'd7:    reg_rdata = 32'(period);
      4'd8:    reg_rdata = {31'h0, running};
      4'd9:    reg_rdata = {8'h0, 8'(di), 8'(si), 1'b0, err_code, 2'b00, phase};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_base <= '0; dst_base <= '0; src_cnt <= '0; dst_cnt <= '0;
      buf_len  <= '0; period   <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        4'd0: src_base[31:0]    <= reg_wdata;
        4'd1: src_base[AW-1:32] <= reg_wdata[AW-33:0];
        4'd2: src_cnt           <= reg_wdata[IDX_W-1:0];
        4'd3: dst_base[31:0]    <= reg_wdata;
        4'd4: dst_base[AW-1:32] <= reg_wdata[AW-33:0];
        4'd5: dst_cnt           <= reg_wdata[IDX_W-1:0];
        4'd6: buf_len           <= reg_wdata[LEN_W-1:0];
        4'd7: period            <= reg_wdata[PER_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; si <= '0; di <= '0; src_pa <= '0; dst_pa <= '0;
      off <= '0; wcnt <= '0; dbuf <= '0; err_code <= '0;
    end else if (stop) begin
      state <= S_IDLE; err_code <= '0;
    end else if (start) begin
      state <= S_SRD; si <= '0; di <= '0; err_code <= '0;
    end else begin
      case (state)
        S_SRD:
          if (bad) begin state <= S_ERR; err_code <= 3'd1; end
          else if (ok) begin
            if (mem_rdata[63]) begin src_pa <= mem_rdata[AW-1:0]; state <= S_DRD; end
            else if (in_order) begin wcnt <= period; state <= S_SWT; end
            else si <= si_nx;
          end
        S_SWT:
          if (wcnt <= PER_W'(1)) state <= S_SRD;
          else wcnt <= wcnt - 1'b1;
        S_DRD:
          if (bad) begin state <= S_ERR; err_code <= 3'd3; end
          else if (ok) begin
            if (!mem_rdata[63]) begin dst_pa <= mem_rdata[AW-1:0]; off <= '0; state <= S_RD; end
            else if (in_order) begin wcnt <= period; state <= S_DWT; end
            else di <= di_nx;
          end
        S_DWT:
          if (wcnt <= PER_W'(1)) state <= S_DRD;
          else wcnt <= wcnt - 1'b1;
        S_RD:
          if (bad) begin state <= S_ERR; err_code <= 3'd2; end
          else if (ok) begin dbuf <= mem_rdata[31:0]; state <= S_WR; end
        S_WR:
          if (bad) begin state <= S_ERR; err_code <= 3'd4; end
          else if (ok) begin
            if (last) state <= S_SWB;
            else begin off <= off + LEN_W'(4); state <= S_RD; end
          end
        S_SWB:
          if (bad) begin state <= S_ERR; err_code <= 3'd1; end
          else if (ok) state <= S_DWB;
        S_DWB:
          if (bad) begin state <= S_ERR; err_code <= 3'd3; end
          else if (ok) begin si <= si_nx; di <= di_nx; state <= S_SRD; end
        default: ;
      endcase
    end
  end

  p_hold_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !ctrl_wr |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_copy_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ok && !mem_we && !mem_wide && !ctrl_wr |=>
      mem_req && mem_we && !mem_wide && mem_wdata[31:0] == $past(mem_rdata[31:0]));

  p_wb_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ok && mem_we && mem_wide && !mem_wdata[63] && !ctrl_wr |=>
      mem_req && mem_we && mem_wide && mem_wdata[63]);

  p_err_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad && !ctrl_wr |=> irq && !mem_req);

  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !irq && !mem_req);

  p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> mem_req && mem_wide && !mem_we);

endmodule

// File: tb/chain_dma_chan_tb.sv
module chain_dma_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 48;
  localparam logic [47:0] SB = 48'h1000, DB = 48'h2000;
  localparam int NS = 4, ND = 3, LEN = 8;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_we, mem_wide, mem_ack = 0, mem_err = 0, irq;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata = 0;

  chain_dma_chan u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] wmem [logic [47:0]];
  logic [47:0] err_addr = 0;
  bit err_en = 0;
  int cyc = 0, n_run = 0, n_fail = 0;

  logic [47:0] o_addr[$], e_addr[$];
  bit o_we[$], o_wide[$], e_we[$], e_wide[$];
  logic [63:0] o_wd[$], e_wd[$];
  int o_cyc[$];

  function automatic logic [31:0] rd32(logic [47:0] a);
    return wmem.exists(a) ? wmem[a] : 32'h0;
  endfunction
  function automatic logic [47:0] sbuf(int i); return 48'h10000 + 48'(i) * 48'h100; endfunction
  function automatic logic [47:0] dbufa(int j); return 48'h20000 + 48'(j) * 48'h100; endfunction
  function automatic logic [31:0] sword(int i, int k); return 32'hA500_0000 | 32'(i << 8) | 32'(k); endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin mem_ack <= 0; mem_err <= 0; end
    else if (mem_req && !mem_ack) begin
      bit e;
      e = err_en && mem_addr == err_addr;
      mem_ack <= 1; mem_err <= e;
      mem_rdata <= mem_wide ? {rd32(mem_addr + 4), rd32(mem_addr)} : {32'h0, rd32(mem_addr)};
      if (mem_we && !e) begin
        wmem[mem_addr] = mem_wdata[31:0];
        if (mem_wide) wmem[mem_addr + 4] = mem_wdata[63:32];
      end
      o_addr.push_back(mem_addr); o_we.push_back(mem_we); o_wide.push_back(mem_wide);
      o_wd.push_back(mem_wdata); o_cyc.push_back(cyc);
    end else begin mem_ack <= 0; mem_err <= 0; end
  end

  always @(posedge clk) if (cyc > 150000) begin
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic reg_write(int a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(int a, output logic [31:0] d);
    @(negedge clk); reg_addr = 4'(a); #1 d = reg_rdata;
  endtask

  task automatic set_desc(logic [47:0] base, int i, bit v, logic [47:0] pa);
    wmem[base + 48'(i) * 8] = pa[31:0];
    wmem[base + 48'(i) * 8 + 4] = {v, 15'h0, pa[47:32]};
  endtask

  task automatic init_mem();
    wmem.delete();
    for (int i = 0; i < NS; i++) begin
      set_desc(SB, i, 0, sbuf(i));
      for (int k = 0; k < LEN/4; k++) wmem[sbuf(i) + 48'(4*k)] = sword(i, k);
    end
    for (int j = 0; j < ND; j++) set_desc(DB, j, 0, dbufa(j));
  endtask

  task automatic configure(int per);
    reg_write(0, SB[31:0]); reg_write(1, 0); reg_write(2, NS);
    reg_write(3, DB[31:0]); reg_write(4, 0); reg_write(5, ND);
    reg_write(6, LEN); reg_write(7, per);
  endtask

  task automatic clear_logs();
    o_addr.delete(); o_we.delete(); o_wide.delete(); o_wd.delete(); o_cyc.delete();
    e_addr.delete(); e_we.delete(); e_wide.delete(); e_wd.delete();
  endtask

  task automatic push_exp(bit we, bit wide, logic [47:0] a, logic [63:0] wd);
    e_we.push_back(we); e_wide.push_back(wide); e_addr.push_back(a); e_wd.push_back(wd);
  endtask

  task automatic exp_copy(int i, int j);
    for (int k = 0; k < LEN/4; k++) begin
      push_exp(0, 0, sbuf(i) + 48'(4*k), 0);
      push_exp(1, 0, dbufa(j) + 48'(4*k), {32'h0, sword(i, k)});
    end
    push_exp(1, 1, SB + 48'(8*i), {1'b0, 15'h0, sbuf(i)});
    push_exp(1, 1, DB + 48'(8*j), {1'b1, 15'h0, dbufa(j)});
  endtask

  task automatic wait_log(int n);
    for (int t = 0; t < 3000 && o_addr.size() < n; t++) @(negedge clk);
  endtask

  task automatic compare_log();
    for (int k = 0; k < e_addr.size(); k++) begin
      string tg;
      tg = e_we[k] ? (e_wide[k] ? "R5 desc writeback" : "R4 data write") : "R2 read address";
      if (k >= o_addr.size()) begin chk({tg, " missing"}, 0, 1); continue; end
      chk(tg, {14'h0, o_we[k], o_wide[k], o_addr[k]}, {14'h0, e_we[k], e_wide[k], e_addr[k]});
      if (e_we[k]) chk(tg, o_wd[k], e_wd[k]);
    end
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    reg_read(7, d); chk("R1 period reset", 64'(d), 0);
    reg_read(9, d); chk("R1 status reset", 64'(d), 0);
    chk("R1 irq reset", 64'(irq), 0);
    chk("R1 no request", 64'(mem_req), 0);

    // In-order mode, period 3
    init_mem();
    set_desc(SB, 0, 1, sbuf(0)); set_desc(SB, 1, 1, sbuf(1));
    configure(3);
    clear_logs();
    reg_write(8, 1);
    push_exp(0, 1, SB, 0); push_exp(0, 1, DB, 0); exp_copy(0, 0);
    push_exp(0, 1, SB + 8, 0); push_exp(0, 1, DB + 8, 0); exp_copy(1, 1);
    push_exp(0, 1, SB + 16, 0); push_exp(0, 1, SB + 16, 0);
    wait_log(18);
    compare_log();
    chk("R6 in-order poll gap", 64'(o_cyc[17] - o_cyc[16]), 3 + 2);
    reg_read(9, d); chk("R11 phase while polling", 64'(d[1:0]), 1);
    set_desc(SB, 2, 1, sbuf(2));
    repeat (200) @(negedge clk);
    chk("R4 dst buf2 word0", 64'(rd32(dbufa(2))), 64'(sword(2, 0)));
    chk("R4 dst buf2 word1", 64'(rd32(dbufa(2) + 4)), 64'(sword(2, 1)));
    chk("R5 dst desc2 full", 64'({rd32(DB + 20), rd32(DB + 16)}), {1'b1, 15'h0, dbufa(2)});
    chk("R5 src desc2 empty", 64'({rd32(SB + 20), rd32(SB + 16)}), {1'b0, 15'h0, sbuf(2)});
    reg_read(9, d);
    chk("R6 src index after wrap", 64'(d[15:8]), 3);
    chk("R6 dst index wraps mod 3", 64'(d[23:16]), 0);
    reg_write(8, 0);
    reg_read(9, d); chk("R9 idle after stop", 64'(d[1:0]), 0);

    // Out-of-order mode, period 0
    init_mem();
    set_desc(SB, 2, 1, sbuf(2)); set_desc(DB, 0, 1, dbufa(0));
    configure(0);
    clear_logs();
    reg_write(8, 1);
    push_exp(0, 1, SB, 0); push_exp(0, 1, SB + 8, 0); push_exp(0, 1, SB + 16, 0);
    push_exp(0, 1, DB, 0); push_exp(0, 1, DB + 8, 0); exp_copy(2, 1);
    push_exp(0, 1, SB + 24, 0); push_exp(0, 1, SB, 0);
    wait_log(13);
    compare_log();
    chk("R7 immediate advance gap", 64'(o_cyc[1] - o_cyc[0]), 2);
    chk("R3 first data read from full source", 64'(o_addr[5]), 64'(sbuf(2)));
    chk("R3 first data write to empty destination", 64'(o_addr[6]), 64'(dbufa(1)));
    reg_write(8, 1);
    repeat (10) @(negedge clk);
    reg_read(9, d);
    chk("R10 start while running ignored", 64'(d[23:16]), 2);
    chk("R7 dst pointer past used", 64'(d[23:16]), 2);
    chk("R11 phase scanning", 64'(d[1:0]), 1);
    reg_write(8, 0);
    chk("R9 irq low after stop", 64'(irq), 0);

    // Error codes
    for (int c = 1; c <= 4; c++) begin
      int nexp;
      init_mem();
      set_desc(SB, 0, 1, sbuf(0));
      case (c)
        1: begin err_addr = SB;        nexp = 1; end
        2: begin err_addr = sbuf(0);   nexp = 3; end
        3: begin err_addr = DB;        nexp = 2; end
        default: begin err_addr = dbufa(0); nexp = 4; end
      endcase
      err_en = 1;
      clear_logs();
      reg_write(8, 1);
      for (int t = 0; t < 500 && !(mem_ack && mem_err); t++) @(negedge clk);
      @(negedge clk);
      chk("R8 irq next cycle", 64'(irq), 1);
      chk("R8 no request after error", 64'(mem_req), 0);
      repeat (5) @(negedge clk);
      chk("R8 no further accesses", 64'(o_addr.size()), 64'(nexp));
      reg_read(9, d);
      chk("R11 error phase", 64'(d[1:0]), 3);
      chk("R8 error code", 64'(d[6:4]), 64'(c));
      reg_write(8, 0);
      reg_read(9, d);
      chk("R9 stop clears error", 64'(d[6:0]), 0);
      chk("R9 stop clears irq", 64'(irq), 0);
      err_en = 0;
    end

    // Stop write in the same cycle as an error response
    init_mem();
    set_desc(SB, 0, 1, sbuf(0));
    err_addr = sbuf(0); err_en = 1;
    reg_write(8, 1);
    for (int t = 0; t < 500 && !(mem_ack && mem_err); t++) @(negedge clk);
    reg_wr = 1; reg_addr = 4'd8; reg_wdata = 0;
    @(negedge clk); reg_wr = 0;
    chk("R9 stop wins over error: irq", 64'(irq), 0);
    chk("R9 stop wins over error: request", 64'(mem_req), 0);
    reg_read(9, d);
    chk("R9 stop wins over error: status", 64'(d[6:0]), 0);
    err_en = 0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule